// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single binary down-counting timer channel with a 16-bit count. It advances only on cycles where the count-enable input is high, so an external prescaler can set the time base. A load strobe writes a new initial count together with a three-bit mode code. The new count takes effect at once. A gate input either suspends counting or retriggers a fresh cycle, depending on the mode. The block drives two outputs: the live count value and a single output level.

Six modes are provided:

| Code | Mode |
|------|------|
| 0 | interrupt on terminal count |
| 1 | retriggerable one-shot |
| 2 | rate generator |
| 3 | square wave |
| 4 | software strobe |
| 5 | hardware strobe |

A loaded count of zero stands for 65536. Bus decoding, byte sequencing, count latching and decimal counting are left to the surrounding logic.

Top module: `timer_chan`

## Requirements
- R1: After reset the count reads 0 and the output is high. The channel ignores count-enable and gate until the first load strobe.
- R2: On a load strobe, the mode code and value are taken, and the count shows the value on the next cycle (rounded as in R7 for mode 3). A value of 0 means a period of 65536. Codes 6 and 7 behave as codes 2 and 3.
- R3: In modes 0, 1, 4 and 5 the count falls by one per counting cycle. From 0 it wraps to 65535 with no reload.
- R4: In mode 0 the output goes low on load and goes high after the counting cycle that takes the count from 1 to 0. It then stays high until the next load.
- R5: In mode 1 the output goes low on load or retrigger, and goes high after the count reaches 0.
- R6: In mode 2 (counts of 2 or more), the count reloads to the initial value after the counting cycle at which it shows 1. The output is low exactly while the count shows 1.
- R7: In mode 3 (counts of 2 or more), the count falls by two per counting cycle and the output toggles at each expiry. The high half lasts ceil(N/2) counting cycles, with the count running from N rounded up to even. The low half lasts floor(N/2) counting cycles, with the count running from N rounded down to even.
- R8: In modes 4 and 5 the output is low for exactly one clock, the one after the counting cycle that takes the count from 1 to 0. This happens only once per load or retrigger.
- R9: In modes 0 and 4, counting happens only while the gate is high. In the other modes the gate level does not pause counting.
- R10: A gate rising edge in modes 1, 2, 3 and 5 reloads the initial count and sets the output as a load would. In modes 0 and 4 a rising edge causes no reload.
- R11: With count-enable low (and no load or retrigger), count and output hold.
- R12: A load strobe takes priority over a retrigger edge and a counting cycle in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Counting qualifier for this cycle |
| gate | input | 1 | Gate: enable level (modes 0, 4) or retrigger edge (1, 2, 3, 5) |
| loadStb | input | 1 | Load a new mode and initial count |
| loadMode | input | 3 | Mode code taken with the load |
| loadValue | input | 16 | Initial count taken with the load, 0 = 65536 |
| count | output | 16 | Live counter value |
| outLevel | output | 1 | Channel output level |

## Verification
A corrupted counter shows on the count port in the very next cycle. A wrong output register shows on outLevel no later than the next expiry, which can be tens of thousands of cycles away for large counts. For that reason the bench compares both ports every cycle against an independent model, and uses short counts in the directed cases. A lost mode-3 phase shows as an odd count value or a half of the wrong length. A missed strobe flag shows as a second low pulse after the count wraps.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

  typedef enum logic [2:0] {
    MODE_TERM_INT  = 3'd0,
    MODE_ONE_SHOT  = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } chanMode_e;

  // control -> datapath
  typedef struct packed {
    logic captureNew;  // take initial value from the load port
    logic reload;      // write the reload value into the counter
    logic roundUp;     // reload value rounded up to even
    logic roundDown;   // reload value rounded down to even
    logic decOne;
    logic decTwo;
  } cntStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic cntIsZero;
    logic cntIsOne;
    logic cntIsTwo;
    logic nextIsOne;
  } cntStatus_t;

  function automatic chanMode_e decodeMode(input logic [2:0] code);
    case (code)
      3'd0:    return MODE_TERM_INT;
      3'd1:    return MODE_ONE_SHOT;
      3'd2, 3'd6: return MODE_RATE;
      3'd3, 3'd7: return MODE_SQUARE;
      3'd4:    return MODE_SW_STROBE;
      default: return MODE_HW_STROBE;
    endcase
  endfunction

endpackage

// File: rtl/timer_chan_datapath.sv
module timer_chan_datapath
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output cntStatus_t       status
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] initQ;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] srcVal;
  logic [CNT_W-1:0] evenUp;
  logic [CNT_W-1:0] evenDown;
  logic [CNT_W-1:0] reloadVal;

  always_comb begin
    srcVal    = strobe.captureNew ? loadValue : initQ;
    evenUp    = srcVal + {{(CNT_W-1){1'b0}}, srcVal[0]};
    evenDown  = {srcVal[CNT_W-1:1], 1'b0};
    if (strobe.roundUp)        reloadVal = evenUp;
    else if (strobe.roundDown) reloadVal = evenDown;
    else                       reloadVal = srcVal;
  end

  always_comb begin
    if (strobe.reload)      countNext = reloadVal;
    else if (strobe.decTwo) countNext = countQ - TWO;
    else if (strobe.decOne) countNext = countQ - ONE;
    else                    countNext = countQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initQ  <= '0;
      countQ <= '0;
    end else begin
      if (strobe.captureNew) initQ <= loadValue;
      countQ <= countNext;
    end
  end

  assign count            = countQ;
  assign status.cntIsZero = (countQ == '0);
  assign status.cntIsOne  = (countQ == ONE);
  assign status.cntIsTwo  = (countQ == TWO);
  assign status.nextIsOne = (countNext == ONE);

  // R3: a single decrement from zero wraps to all ones
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decOne && !strobe.reload && countQ == '0) |=> (countQ == '1));

endmodule

// File: rtl/timer_chan_ctrl.sv
module timer_chan_ctrl
  import timer_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       countEn,
  input  logic       gate,
  input  logic       loadStb,
  input  logic [2:0] loadMode,
  input  cntStatus_t status,
  output cntStrobe_t strobe,
  output logic       outLevel,
  output chanMode_e  curMode,
  output logic       armed
);

  chanMode_e modeQ;
  chanMode_e newMode;
  chanMode_e startMode;
  logic      armedQ;
  logic      outQ;
  logic      outNext;
  logic      firedQ;
  logic      firedNext;
  logic      gatePrevQ;
  logic      gateRise;
  logic      gateLevelMode;
  logic      edgeMode;
  logic      trigger;
  logic      restart;
  logic      tick;
  logic      sqExpire;
  logic      rateExpire;
  logic      strobePulse;

  assign newMode       = decodeMode(loadMode);
  assign gateRise      = gate && !gatePrevQ;
  assign gateLevelMode = (modeQ == MODE_TERM_INT) || (modeQ == MODE_SW_STROBE);
  assign edgeMode      = !gateLevelMode;
  assign trigger       = armedQ && !loadStb && gateRise && edgeMode;
  assign restart       = loadStb || trigger;
  assign startMode     = loadStb ? newMode : modeQ;
  assign tick          = armedQ && !restart && countEn && (gateLevelMode ? gate : 1'b1);
  assign sqExpire      = tick && (modeQ == MODE_SQUARE) && status.cntIsTwo;
  assign rateExpire    = tick && (modeQ == MODE_RATE) && status.cntIsOne;
  assign strobePulse   = tick && (modeQ == MODE_SW_STROBE || modeQ == MODE_HW_STROBE)
                         && status.cntIsOne && !firedQ;

  always_comb begin
    strobe            = '0;
    strobe.captureNew = loadStb;
    strobe.reload     = restart || sqExpire || rateExpire;
    strobe.roundUp    = (restart && startMode == MODE_SQUARE) || (sqExpire && !outQ);
    strobe.roundDown  = sqExpire && outQ;
    strobe.decTwo     = tick && (modeQ == MODE_SQUARE) && !status.cntIsTwo;
    strobe.decOne     = tick && (modeQ != MODE_SQUARE) && !rateExpire;
  end

  always_comb begin
    outNext   = outQ;
    firedNext = firedQ;
    if (restart) begin
      firedNext = 1'b0;
      case (startMode)
        MODE_TERM_INT, MODE_ONE_SHOT: outNext = 1'b0;
        MODE_RATE:                    outNext = !status.nextIsOne;
        default:                      outNext = 1'b1;
      endcase
    end else if (armedQ) begin
      case (modeQ)
        MODE_TERM_INT, MODE_ONE_SHOT: if (tick && status.cntIsOne) outNext = 1'b1;
        MODE_RATE:                    if (tick) outNext = !status.nextIsOne;
        MODE_SQUARE:                  if (sqExpire) outNext = !outQ;
        default: begin
          outNext = !strobePulse;
          if (strobePulse) firedNext = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_TERM_INT;
      armedQ    <= 1'b0;
      outQ      <= 1'b1;
      firedQ    <= 1'b0;
      gatePrevQ <= 1'b0;
    end else begin
      gatePrevQ <= gate;
      outQ      <= outNext;
      firedQ    <= firedNext;
      if (loadStb) begin
        modeQ  <= newMode;
        armedQ <= 1'b1;
      end
    end
  end

  assign outLevel = outQ;
  assign curMode  = modeQ;
  assign armed    = armedQ;

  // R1: before the first load the channel sits at zero with output high
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (outQ && status.cntIsZero));

  // R8: strobe pulse lasts one clock
  assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !outQ && !loadStb &&
     (modeQ == MODE_SW_STROBE || modeQ == MODE_HW_STROBE)) |=> outQ);

  // R4: terminal-count output does not fall without a load
  assert_term_stays_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && outQ && !loadStb && modeQ == MODE_TERM_INT) |=> outQ);

endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             gate,
  input  logic             loadStb,
  input  logic [2:0]       loadMode,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             outLevel
);

  cntStrobe_t strobe;
  cntStatus_t status;
  chanMode_e  curMode;
  logic       armed;

  timer_chan_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .countEn  (countEn),
    .gate     (gate),
    .loadStb  (loadStb),
    .loadMode (loadMode),
    .status   (status),
    .strobe   (strobe),
    .outLevel (outLevel),
    .curMode  (curMode),
    .armed    (armed)
  );

  timer_chan_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadValue (loadValue),
    .count     (count),
    .status    (status)
  );

  // R2: a plain load shows its value on the next cycle
  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && loadMode[1:0] != 2'd3) |=> (count == $past(loadValue)));

  // R7: square-wave count stays even
  assert_square_even_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && curMode == MODE_SQUARE) |-> !count[0]);

  // R6: rate output is low only while the count shows one
  assert_rate_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && curMode == MODE_RATE && !outLevel) |-> (count == CNT_W'(1)));

  // R9: gate low freezes the count in level-gated modes
  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !gate && !loadStb &&
     (curMode == MODE_TERM_INT || curMode == MODE_SW_STROBE)) |=> $stable(count));

  // R11: no count enable, no load, no gate edge -> count holds
  assert_no_enable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !loadStb && gate == 1'b0) |=> $stable(count));

endmodule

// File: tb/tb_timer_chan.sv
module tb_timer_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countEn = 1'b0;
  logic        gate = 1'b0;
  logic        loadStb = 1'b0;
  logic [2:0]  loadMode = '0;
  logic [15:0] loadValue = '0;
  logic [15:0] count;
  logic        outLevel;

  int checks = 0;
  int failures = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  // model state
  int          mMode;
  bit          mArmed, mOut, mFired, mGatePrev;
  logic [15:0] mCount, mInit;

  always #2 clk = ~clk;

  timer_chan dut (
    .clk(clk), .rstN(rstN), .countEn(countEn), .gate(gate),
    .loadStb(loadStb), .loadMode(loadMode), .loadValue(loadValue),
    .count(count), .outLevel(outLevel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int aliasMode(input logic [2:0] c);
    if (c == 3'd6) return 2;
    if (c == 3'd7) return 3;
    return int'(c);
  endfunction

  function automatic string modeReq(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic modelRestart();
    mFired = 1'b0;
    mCount = (mMode == 3) ? mInit + {15'd0, mInit[0]} : mInit;
    if (mMode == 0 || mMode == 1) mOut = 1'b0;
    else if (mMode == 2)          mOut = (mCount != 16'd1);
    else                          mOut = 1'b1;
  endtask

  task automatic modelTick();
    case (mMode)
      0, 1: begin
        if (mCount == 16'd1) mOut = 1'b1;
        mCount = mCount - 16'd1;
      end
      2: begin
        if (mCount == 16'd1) mCount = mInit;
        else                 mCount = mCount - 16'd1;
        mOut = (mCount != 16'd1);
      end
      3: begin
        if (mCount == 16'd2) begin
          mCount = mOut ? {mInit[15:1], 1'b0} : mInit + {15'd0, mInit[0]};
          mOut = !mOut;
        end else mCount = mCount - 16'd2;
      end
      default: begin
        if (mCount == 16'd1 && !mFired) begin
          mOut = 1'b0;
          mFired = 1'b1;
        end
        mCount = mCount - 16'd1;
      end
    endcase
  endtask

  // independent cycle model of the requirements
  always @(posedge clk) begin
    bit rise;
    if (!rstN) begin
      mMode = 0; mArmed = 0; mOut = 1; mFired = 0; mGatePrev = 0;
      mCount = '0; mInit = '0;
    end else begin
      rise = gate && !mGatePrev;
      mGatePrev = gate;
      if (mArmed && (mMode == 4 || mMode == 5)) mOut = 1'b1;
      if (loadStb) begin
        mMode = aliasMode(loadMode);
        mInit = loadValue;
        mArmed = 1'b1;
        modelRestart();
      end else if (mArmed && rise && mMode != 0 && mMode != 4) begin
        modelRestart();
      end else if (mArmed && countEn &&
                   ((mMode == 0 || mMode == 4) ? gate : 1'b1)) begin
        modelTick();
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check(mArmed ? modeReq(mMode) : "R1", int'(count), int'(mCount));
      check(mArmed ? modeReq(mMode) : "R1", int'(outLevel), int'(mOut));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(input logic [2:0] m, input logic [15:0] v);
    loadMode = m; loadValue = v; loadStb = 1'b1;
    step(1);
    loadStb = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    step(3);
    rstN = 1'b1;
    step(1);
    modelOn = 1'b1;
    check("R1", count, 0);
    check("R1", outLevel, 1);
    countEn = 1'b1; gate = 1'b1;
    step(5);
    check("R1", count, 0);
    check("R1", outLevel, 1);

    // mode 0 basic run and wrap
    doLoad(3'd0, 16'd5);
    check("R2", count, 5);
    check("R4", outLevel, 0);
    step(4);
    check("R4", outLevel, 0);
    step(1);
    check("R4", count, 0);
    check("R4", outLevel, 1);
    step(1);
    check("R3", count, 65535);
    check("R4", outLevel, 1);

    // gate level pauses mode 0
    doLoad(3'd0, 16'd10);
    gate = 1'b0;
    step(3);
    check("R9", count, 10);
    gate = 1'b1;
    step(2);
    check("R10", count, 8);
    countEn = 1'b0;
    step(3);
    check("R11", count, 8);
    check("R11", outLevel, 0);
    countEn = 1'b1;

    // zero means 65536
    doLoad(3'd4, 16'd0);
    check("R2", count, 0);
    step(1);
    check("R2", count, 65535);

    // rate generator
    doLoad(3'd2, 16'd4);
    check("R6", count, 4);
    check("R6", outLevel, 1);
    step(3);
    check("R6", count, 1);
    check("R6", outLevel, 0);
    step(1);
    check("R6", count, 4);
    check("R6", outLevel, 1);

    // square wave, odd count
    doLoad(3'd3, 16'd5);
    check("R7", count, 6);
    check("R7", outLevel, 1);
    step(2);
    check("R7", outLevel, 1);
    step(1);
    check("R7", count, 4);
    check("R7", outLevel, 0);
    step(2);
    check("R7", count, 6);
    check("R7", outLevel, 1);

    // software strobe
    doLoad(3'd4, 16'd3);
    step(2);
    check("R8", count, 1);
    check("R8", outLevel, 1);
    step(1);
    check("R8", count, 0);
    check("R8", outLevel, 0);
    step(1);
    check("R8", outLevel, 1);
    check("R3", count, 65535);

    // one-shot retrigger; gate level does not pause
    gate = 1'b0;
    doLoad(3'd1, 16'd6);
    step(3);
    check("R9", count, 3);
    check("R5", outLevel, 0);
    gate = 1'b1;
    step(1);
    check("R10", count, 6);
    check("R5", outLevel, 0);
    step(6);
    check("R5", count, 0);
    check("R5", outLevel, 1);

    // mode 0 ignores rising edge
    gate = 1'b0;
    doLoad(3'd0, 16'd6);
    step(2);
    check("R9", count, 6);
    gate = 1'b1;
    step(1);
    check("R10", count, 5);

    // alias code 6 acts as rate generator
    doLoad(3'd6, 16'd3);
    step(2);
    check("R2", count, 1);
    check("R2", outLevel, 0);

    // load beats retrigger and tick
    doLoad(3'd5, 16'd7);
    step(2);
    gate = 1'b0;
    step(1);
    gate = 1'b1;
    doLoad(3'd5, 16'd9);
    check("R12", count, 9);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      logic [2:0]  m;
      logic [15:0] v;
      countEn = ($urandom % 4) != 0;
      if ($urandom % 16 == 0) gate = !gate;
      if ($urandom % 90 == 0) begin
        m = 3'($urandom % 8);
        case ($urandom % 4)
          0: v = 16'(2 + $urandom % 19);
          1: v = 16'd0;
          2: v = 16'($urandom);
          default: v = 16'd65535;
        endcase
        if (v == 16'd1) v = 16'd2;
        loadMode = m; loadValue = v; loadStb = 1'b1;
      end else begin
        loadStb = 1'b0;
      end
      step(1);
    end
    loadStb = 1'b0;
    step(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule